// File: doc/BRIEF.md
# Compressed Stream FIFO Drain

This controller empties the output buffer of a slave video encoder into a downstream byte consumer. The encoder fills a 256-byte output buffer and raises a buffer-full interrupt each time it does. The controller then performs one register read per byte of the encoder's data-out register through a simple request/acknowledge register port. It hands each byte to a valid/ready stream output. It then reads the encoder's status register to clear the interrupt and waits for the next one.

A start pulse arms the controller. Arming first enables both interrupt sources in the encoder. After that the controller drains one burst per buffer-full interrupt until an end-of-stream interrupt arrives. It clears that interrupt, raises `done` and returns to idle. An end-of-stream event seen during a burst is remembered, and it takes effect only once the whole burst has been delivered. A stop pulse abandons the transfer at once. Running counts of delivered bytes and completed bursts are kept and cleared on each start.

Top module: `stream_drain`

## Requirements
- R1: A start pulse while idle causes exactly one register write, of value 0x03 to address 0x0C (interrupt enable), after which the block waits with `busy` high.
- R2: A buffer-full interrupt while waiting causes exactly 256 reads of the data-out register (address 0x02). Each byte read is delivered on `outData` in the order it was read.
- R3: After the 256th byte of a burst is accepted downstream, the block performs one read of the status register (address 0x0E), increments `blockCount` and returns to waiting.
- R4: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged, so no byte is dropped or repeated.
- R5: An end-of-stream interrupt while waiting causes one status read (0x0E), after which `busy` falls and `done` rises.
- R6: An end-of-stream interrupt that arrives during a burst is held. The burst still completes all 256 bytes and its own status read before the end-of-stream status read is made.
- R7: `byteCount` (32 bits) increases by one for each byte accepted downstream and is otherwise unchanged. `byteCount` and `blockCount` both clear to zero on start.
- R8: A stop pulse while busy returns the block to idle on the next cycle, with `outValid` and `regReq` low and the counts kept.
- R9: While idle, interrupts are ignored and no register request is issued.
- R10: Once `regReq` is raised, `regReq`, `regWrite`, `regAddr` and `regWdata` hold steady until `regAck` completes the access.
- R11: A buffer-full interrupt that arrives during a burst is ignored and adds no data-out reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: arm and begin a stream (idle only) |
| stop | input | 1 | Pulse: abandon the transfer |
| irqFifoRdy | input | 1 | Encoder buffer-full interrupt pulse |
| irqEod | input | 1 | Encoder end-of-stream interrupt pulse |
| regReq | output | 1 | Register access request |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 8 | Register index |
| regWdata | output | 8 | Write data |
| regAck | input | 1 | Access completes in a cycle with regReq and regAck high |
| regRdata | input | 8 | Read data, valid with regAck |
| outValid | output | 1 | Stream byte valid |
| outData | output | 8 | Stream byte |
| outReady | input | 1 | Downstream ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Stream ended by end-of-stream interrupt |
| byteCount | output | 32 | Bytes delivered since start |
| blockCount | output | 16 | Bursts completed since start |

## Verification
The hardest case to reach is an end-of-stream interrupt that lands in the middle of a burst while the downstream side is applying backpressure. The stimulus must also vary the register acknowledge latency at the same time. The bench models the encoder's register port and the byte sink in one process. It fires the end-of-stream pulse after a chosen number of bytes of the last burst have been accepted. It then checks that every byte of that burst came out in order before the final status read, counting accepted bytes at the moment of that read.

// File: rtl/drain_pkg.sv
package drain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_WAIT, ST_READ, ST_PUSH, ST_BLKCLR, ST_ENDCLR
  } drainState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCounts;
    logic loadByte;
    logic byteSent;
    logic blockDone;
  } drainStrb_t;
endpackage

// File: rtl/drain_ctrl.sv
module drain_ctrl
  import drain_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_IRQ_EN = 'h0C,
  parameter logic [ADDR_W-1:0] REG_STATUS = 'h0E,
  parameter logic [ADDR_W-1:0] REG_DOUT   = 'h02,
  parameter logic [DATA_W-1:0] IRQ_EN_VAL = 'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic              irqFifoRdy,
  input  logic              irqEod,
  input  logic              regAck,
  input  logic              outReady,
  input  logic              burstLast,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              outValid,
  output logic              busy,
  output logic              done,
  output drainStrb_t        strb
);
  drainState_e state, nextState;
  logic eodPend;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (start) nextState = ST_ARM;
      ST_ARM:    if (regAck) nextState = ST_WAIT;
      ST_WAIT: begin
        if (irqFifoRdy)              nextState = ST_READ;
        else if (eodPend || irqEod)  nextState = ST_ENDCLR;
      end
      ST_READ:   if (regAck) nextState = ST_PUSH;
      ST_PUSH:   if (outReady) nextState = burstLast ? ST_BLKCLR : ST_READ;
      ST_BLKCLR: if (regAck) nextState = ST_WAIT;
      ST_ENDCLR: if (regAck) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
    if (stop && state != ST_IDLE) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      eodPend <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        eodPend <= 1'b0;
        done    <= 1'b0;
      end else if (stop) begin
        eodPend <= 1'b0;
      end else if (state == ST_ENDCLR && regAck) begin
        eodPend <= 1'b0;
        done    <= 1'b1;
      end else if (irqEod && state != ST_IDLE) begin
        eodPend <= 1'b1;
      end
    end
  end

  always_comb begin
    regReq   = state inside {ST_ARM, ST_READ, ST_BLKCLR, ST_ENDCLR};
    regWrite = (state == ST_ARM);
    regWdata = (state == ST_ARM) ? IRQ_EN_VAL : '0;
    unique case (state)
      ST_ARM:  regAddr = REG_IRQ_EN;
      ST_READ: regAddr = REG_DOUT;
      default: regAddr = REG_STATUS;
    endcase
    outValid       = (state == ST_PUSH);
    busy           = (state != ST_IDLE);
    strb.clrCounts = (state == ST_IDLE) && start;
    strb.loadByte  = (state == ST_READ) && regAck;
    strb.byteSent  = (state == ST_PUSH) && outReady;
    strb.blockDone = (state == ST_BLKCLR) && regAck;
  end
endmodule

// File: rtl/drain_path.sv
module drain_path
  import drain_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 32,
  parameter int BLK_W       = 16,
  parameter int BURST_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  drainStrb_t        strb,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  byteCount,
  output logic [BLK_W-1:0]  blockCount,
  output logic              burstLast
);
  localparam int IDX_W = (BURST_BYTES > 1) ? $clog2(BURST_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_BYTES - 1);

  logic [IDX_W-1:0] burstIdx;

  assign burstLast = (burstIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData    <= '0;
      byteCount  <= '0;
      blockCount <= '0;
      burstIdx   <= '0;
    end else begin
      if (strb.loadByte) outData <= regRdata;
      if (strb.clrCounts) begin
        byteCount  <= '0;
        blockCount <= '0;
        burstIdx   <= '0;
      end else begin
        if (strb.byteSent) begin
          byteCount <= byteCount + 1'b1;
          burstIdx  <= burstLast ? '0 : burstIdx + 1'b1;
        end
        if (strb.blockDone) blockCount <= blockCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stream_drain.sv
module stream_drain
  import drain_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 32,
  parameter int BLK_W       = 16,
  parameter int BURST_BYTES = 256,
  parameter logic [ADDR_W-1:0] REG_IRQ_EN = 'h0C,
  parameter logic [ADDR_W-1:0] REG_STATUS = 'h0E,
  parameter logic [ADDR_W-1:0] REG_DOUT   = 'h02,
  parameter logic [DATA_W-1:0] IRQ_EN_VAL = 'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic              irqFifoRdy,
  input  logic              irqEod,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRdata,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  byteCount,
  output logic [BLK_W-1:0]  blockCount
);
  drainStrb_t strb;
  logic burstLast;

  drain_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_IRQ_EN(REG_IRQ_EN),
    .REG_STATUS(REG_STATUS), .REG_DOUT(REG_DOUT), .IRQ_EN_VAL(IRQ_EN_VAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .irqFifoRdy(irqFifoRdy), .irqEod(irqEod), .regAck(regAck),
    .outReady(outReady), .burstLast(burstLast), .regReq(regReq),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .outValid(outValid), .busy(busy), .done(done), .strb(strb)
  );

  drain_path #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .BLK_W(BLK_W), .BURST_BYTES(BURST_BYTES)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .regRdata(regRdata),
    .outData(outData), .byteCount(byteCount), .blockCount(blockCount),
    .burstLast(burstLast)
  );
endmodule

// File: rtl/drain_checker.sv
module drain_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              stop,
  input logic              busy,
  input logic              done,
  input logic              regReq,
  input logic              regAck,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [CNT_W-1:0]  byteCount
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck && !stop) |=> (regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata))); // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !stop) |=> (outValid && $stable(outData))); // R4
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (byteCount == $past(byteCount) + 1'b1)); // R7
  AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!(outValid && outReady) && !start) |=> $stable(byteCount)); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (!busy && !outValid && !regReq)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!regReq && !outValid)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy); // R5
endmodule

bind stream_drain drain_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .stop(stop), .busy(busy), .done(done),
  .regReq(regReq), .regAck(regAck), .regWrite(regWrite), .regAddr(regAddr),
  .regWdata(regWdata), .outValid(outValid), .outReady(outReady),
  .outData(outData), .byteCount(byteCount)
);

// File: tb/tb_stream_drain.sv
module tb_stream_drain;
  localparam int CLK_PERIOD = 10;
  localparam int BURST = 256;
  localparam int NVEC = 6;
  // {bursts[3:0], readyMode[1:0], eodMidBurst, ackDelay[1:0], extraRdyMidBurst}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd1, 2'd0, 1'b0, 2'd0, 1'b0},
    {4'd3, 2'd1, 1'b0, 2'd1, 1'b0},
    {4'd2, 2'd2, 1'b1, 2'd0, 1'b0},
    {4'd2, 2'd0, 1'b1, 2'd2, 1'b1},
    {4'd4, 2'd1, 1'b0, 2'd0, 1'b1},
    {4'd0, 2'd0, 1'b0, 2'd1, 1'b0}
  };

  logic clk = 0, rstN = 0, start = 0, stop = 0, irqFifoRdy = 0, irqEod = 0;
  logic regReq, regWrite, regAck = 0, outValid, outReady = 0, busy, done;
  logic [7:0] regAddr, regWdata, regRdata = 0, outData;
  logic [31:0] byteCount;
  logic [15:0] blockCount;

  int total = 0, bad = 0, cyc = 0;
  int writes, dataReads, statusReads, reqSeen, accepted, mism, acceptedAtStatus;
  int dlyCnt, ackDly, readyMode;
  logic [7:0] lastWAddr, lastWData, srcByte, expByte;

  stream_drain dut (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .irqFifoRdy(irqFifoRdy),
    .irqEod(irqEod), .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata), .outValid(outValid),
    .outData(outData), .outReady(outReady), .busy(busy), .done(done),
    .byteCount(byteCount), .blockCount(blockCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // encoder register port model and byte sink, evaluated for the coming edge
  always @(negedge clk) begin
    logic rdy;
    cyc = cyc + 1;
    if (regAck) regAck = 0;
    else if (regReq) begin
      if (dlyCnt < ackDly) dlyCnt = dlyCnt + 1;
      else begin
        dlyCnt = 0;
        regAck = 1;
        reqSeen = reqSeen + 1;
        if (regWrite) begin
          writes = writes + 1; lastWAddr = regAddr; lastWData = regWdata;
        end else if (regAddr == 8'h02) begin
          dataReads = dataReads + 1; regRdata = srcByte; srcByte = srcByte + 1;
        end else if (regAddr == 8'h0E) begin
          statusReads = statusReads + 1; acceptedAtStatus = accepted;
        end
      end
    end
    rdy = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? cyc[0] : (cyc[1:0] == 2'd0);
    if (outValid && rdy) begin
      if (outData != expByte) mism = mism + 1;
      expByte = expByte + 1;
      accepted = accepted + 1;
    end
    outReady = rdy;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearTally();
    writes = 0; dataReads = 0; statusReads = 0; reqSeen = 0; accepted = 0;
    mism = 0; acceptedAtStatus = 0; srcByte = 8'h5A; expByte = 8'h5A; dlyCnt = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic runStream(input logic [9:0] v);
    int n;
    n = v[9:6]; readyMode = v[5:4]; ackDly = v[2:1];
    clearTally();
    pulse(start);
    chk(byteCount == 0 && blockCount == 0, "R7 clear on start", byteCount, 0);
    repeat (8) @(negedge clk);
    chk(busy == 1, "R1 waiting busy", busy, 1);
    for (int b = 0; b < n; b++) begin
      pulse(irqFifoRdy);
      if (v[0] && b == 0) begin
        while (accepted < 50) @(negedge clk);
        pulse(irqFifoRdy); // R11 ignored mid-burst
      end
      if (v[3] && b == n - 1) begin
        while (accepted < b * BURST + 100) @(negedge clk);
        pulse(irqEod); // R6 latched
      end
      while (statusReads < b + 1) @(negedge clk);
      repeat (3) @(negedge clk);
    end
    if (!v[3]) pulse(irqEod);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(writes == 1 && lastWAddr == 8'h0C && lastWData == 8'h03, "R1 enable write",
        {lastWAddr, lastWData}, 16'h0C03);
    chk(dataReads == n * BURST, "R2/R11 data reads", dataReads, n * BURST);
    chk(mism == 0, "R2/R4 byte order", mism, 0);
    chk(blockCount == n, "R3 block count", blockCount, n);
    chk(statusReads == n + 1, "R3/R5 status reads", statusReads, n + 1);
    chk(byteCount == n * BURST, "R7 byte count", byteCount, n * BURST);
    chk(acceptedAtStatus == n * BURST, "R6 final clear after burst", acceptedAtStatus, n * BURST);
    chk(!busy && done, "R5 done idle", {busy, done}, 1);
  endtask

  initial begin
    readyMode = 0; ackDly = 0;
    clearTally();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !outValid && !regReq && byteCount == 0, "R9 reset state",
        {busy, done, outValid, regReq}, 0);
    rstN = 1;
    @(negedge clk);
    pulse(irqFifoRdy);
    pulse(irqEod);
    repeat (5) @(negedge clk);
    chk(reqSeen == 0 && !outValid && !busy, "R9 idle ignores irq", reqSeen, 0);
    chk(!done, "R9 idle eod no done", done, 0);

    for (int i = 0; i < NVEC; i++) runStream(VEC[i]);

    // stop mid-burst
    readyMode = 1; ackDly = 0;
    clearTally();
    pulse(start);
    repeat (6) @(negedge clk);
    pulse(irqFifoRdy);
    while (accepted < 10) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    chk(!busy && !outValid && !regReq, "R8 stop to idle", {busy, outValid, regReq}, 0);
    repeat (2) @(negedge clk);
    chk(byteCount == accepted, "R8 count kept", byteCount, accepted);
    chk(!done, "R8 no done on stop", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule